// File: doc/BRIEF.md
# ULPI PHY Register Viewport Engine

This block lets software reach the registers inside an external ULPI transceiver through one 32-bit viewport word. Software writes the word with a target address, write data, a direction bit and a start bit. The engine then runs a single register write or register read on the 8-bit ULPI bus. When it finishes, the start bit drops back to zero by itself. After a read, the byte returned by the PHY appears in the read-data field.

A separate start bit in the same word runs a wakeup sequence instead. The engine holds stop high while the PHY keeps the direction line high, and it releases stop once the PHY hands the bus back.

The CPU side is a plain write strobe plus a read-back word. It has no back-pressure. Every strobe is sampled. A strobe that arrives while an operation is in flight is dropped whole. On the ULPI side, flow control comes only from the PHY's nxt and dir lines.

Top module: `ulpi_viewport`

## Requirements
- R1: The read-back word places write data in [7:0], read data in [15:8], address in [23:16], port number in [26:24], sync state in [27], a constant zero in [28], direction in [29] (0 = read, 1 = write), run in [30] and wakeup in [31].
- R2: A strobe taken while idle with both [30] and [31] at zero stores the write data, address, port and direction fields. It starts no bus activity and leaves the output enable low.
- R3: A write (direction 1) drives the byte {2'b10, address[5:0]} with the output enable high until nxt is sampled high. It then drives the write data until nxt is sampled high. It then drives 8'h00 with stp high for exactly one cycle.
- R4: A read (direction 0) drives {2'b11, address[5:0]} until nxt is sampled high and then releases the bus. It waits for dir to be sampled high, then captures ulpi_data_i on the next clock edge into [15:8].
- R5: The run bit reads 1 from the cycle after the starting strobe until the operation completes, then reads 0. Software writes cannot clear it early.
- R6: If dir is sampled high while the command byte is being driven, the engine releases the bus, waits for dir to be sampled low, and then drives the command byte again.
- R7: A wakeup holds stp high and wakeup bit [31] at 1 for as long as dir is sampled high. Both fall in the cycle after dir is sampled low.
- R8: While run or wakeup reads 1, a strobe changes no field of the read-back word and starts nothing.
- R9: A strobe with both [30] and [31] set starts only the register operation, and the wakeup bit stays 0.
- R10: Bit [27] follows the phy_sync input in the same cycle.
- R11: After reset every field of the read-back word is zero apart from [27], the output enable and stp are low, and the data output is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the ULPI 60 MHz domain in use |
| rst_n | input | 1 | Active-low synchronous reset |
| vp_wr_en | input | 1 | Viewport write strobe, one cycle |
| vp_wr_data | input | 32 | Viewport word written by software |
| vp_rd_data | output | 32 | Viewport word read back by software |
| phy_sync | input | 1 | 1 when the PHY interface is in normal synchronous mode |
| ulpi_dir | input | 1 | ULPI direction, PHY owns the bus when high |
| ulpi_nxt | input | 1 | ULPI next, PHY accepts or presents a byte |
| ulpi_data_i | input | 8 | ULPI data from the PHY |
| ulpi_data_o | output | 8 | ULPI data to the PHY |
| ulpi_data_oe | output | 1 | Drive enable for ulpi_data_o |
| ulpi_stp | output | 1 | ULPI stop |

## Verification
The assertions check four things on every cycle. Stop lasts one cycle after a register write. The run and wakeup bits never read 1 together and never fall while the PHY still owns the bus or before the final phase. The stored fields hold still while an operation is busy. The command byte always carries the opcode that matches the direction bit.

Some behaviour only the bench scenarios can show. These are the exact byte order on the bus under stalled nxt, the captured read value, the retry after dir takes the bus mid-command, and the dropping of strobes that try to clear run or change fields mid-operation. A behavioural reference model checks the outputs every clock while those scenarios run.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int PORT_W     = 3;
  localparam int CMD_ADDR_W = 6;

  // bit positions software decodes
  localparam int POS_WDATA = 0;
  localparam int POS_RDATA = 8;
  localparam int POS_ADDR  = 16;
  localparam int POS_PORT  = 24;
  localparam int POS_SYNC  = 27;
  localparam int POS_DIR   = 29;
  localparam int POS_RUN   = 30;
  localparam int POS_WAKE  = 31;

  localparam logic [1:0] OPC_WRITE = 2'b10;
  localparam logic [1:0] OPC_READ  = 2'b11;

  typedef enum logic [2:0] {
    VP_IDLE, VP_CMD, VP_HOLD, VP_WDATA, VP_WSTOP, VP_TURN, VP_RCAPT, VP_WAKE
  } vp_state_e;
endpackage

// File: rtl/ulpi_vp_fields.sv
module ulpi_vp_fields
  import ulpi_vp_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int PW = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              cap_en,
  input  logic [DW-1:0]     cap_data,
  output logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     addr,
  output logic [PW-1:0]     port,
  output logic              is_write
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata    <= '0;
      addr     <= '0;
      port     <= '0;
      is_write <= 1'b0;
    end else if (load) begin
      wdata    <= word_in[POS_WDATA +: DW];
      addr     <= word_in[POS_ADDR +: DW];
      port     <= word_in[POS_PORT +: PW];
      is_write <= word_in[POS_DIR];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= cap_data;
  end
endmodule

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = CMD_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rw,
  input  logic          start_wake,
  input  logic          is_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wdata,
  input  logic          dir,
  input  logic          nxt,
  output vp_state_e     state,
  output logic          idle,
  output logic          cap_en,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          stp
);
  localparam int PAD_W = DW - AW - 2;

  vp_state_e nxt_state;

  always_comb begin
    nxt_state = state;
    unique case (state)
      VP_IDLE:  if (start_rw) nxt_state = VP_CMD;
                else if (start_wake) nxt_state = VP_WAKE;
      VP_CMD:   if (dir) nxt_state = VP_HOLD;
                else if (nxt) nxt_state = is_write ? VP_WDATA : VP_TURN;
      VP_HOLD:  if (!dir) nxt_state = VP_CMD;
      VP_WDATA: if (nxt) nxt_state = VP_WSTOP;
      VP_WSTOP: nxt_state = VP_IDLE;
      VP_TURN:  if (dir) nxt_state = VP_RCAPT;
      VP_RCAPT: nxt_state = VP_IDLE;
      VP_WAKE:  if (!dir) nxt_state = VP_IDLE;
      default:  nxt_state = VP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= VP_IDLE;
    else        state <= nxt_state;
  end

  logic [1:0] opcode;
  assign opcode = is_write ? OPC_WRITE : OPC_READ;

  generate
    if (PAD_W > 0) begin : g_pad
      logic [DW-1:0] cmd_byte;
      assign cmd_byte = {opcode, {PAD_W{1'b0}}, cmd_addr};
      assign data_o = (state == VP_CMD) ? cmd_byte :
                      (state == VP_WDATA) ? wdata : '0;
    end else begin : g_nopad
      assign data_o = (state == VP_CMD) ? {opcode, cmd_addr} :
                      (state == VP_WDATA) ? wdata : '0;
    end
  endgenerate

  assign idle    = (state == VP_IDLE);
  assign cap_en  = (state == VP_RCAPT);
  assign data_oe = (state == VP_CMD) || (state == VP_WDATA) || (state == VP_WSTOP);
  assign stp     = (state == VP_WSTOP) || (state == VP_WAKE);
endmodule

// File: rtl/ulpi_viewport.sv
module ulpi_viewport
  import ulpi_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vp_wr_en,
  input  logic [WORD_W-1:0] vp_wr_data,
  output logic [WORD_W-1:0] vp_rd_data,
  input  logic              phy_sync,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [BYTE_W-1:0] ulpi_data_i,
  output logic [BYTE_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);
  vp_state_e         state_q;
  logic              idle;
  logic              cap_en;
  logic              load;
  logic [BYTE_W-1:0] f_wdata, f_rdata, f_addr;
  logic [PORT_W-1:0] f_port;
  logic              f_write;
  logic              run_bit, wake_bit;

  assign load = vp_wr_en && idle;

  ulpi_vp_fields #(.DW(BYTE_W), .PW(PORT_W)) u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word_in  (vp_wr_data),
    .cap_en   (cap_en),
    .cap_data (ulpi_data_i),
    .wdata    (f_wdata),
    .rdata    (f_rdata),
    .addr     (f_addr),
    .port     (f_port),
    .is_write (f_write)
  );

  ulpi_vp_seq #(.DW(BYTE_W), .AW(CMD_ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rw   (load && vp_wr_data[POS_RUN]),
    .start_wake (load && vp_wr_data[POS_WAKE]),
    .is_write   (f_write),
    .cmd_addr   (f_addr[CMD_ADDR_W-1:0]),
    .wdata      (f_wdata),
    .dir        (ulpi_dir),
    .nxt        (ulpi_nxt),
    .state      (state_q),
    .idle       (idle),
    .cap_en     (cap_en),
    .data_o     (ulpi_data_o),
    .data_oe    (ulpi_data_oe),
    .stp        (ulpi_stp)
  );

  assign wake_bit = (state_q == VP_WAKE);
  assign run_bit  = !idle && !wake_bit;

  assign vp_rd_data = {wake_bit, run_bit, f_write, 1'b0, phy_sync,
                       f_port, f_addr, f_rdata, f_wdata};
endmodule

// File: rtl/ulpi_viewport_chk.sv
module ulpi_viewport_chk
  import ulpi_vp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input vp_state_e         state_q,
  input logic [WORD_W-1:0] vp_rd_data,
  input logic              ulpi_dir,
  input logic [BYTE_W-1:0] ulpi_data_o,
  input logic              ulpi_data_oe,
  input logic              ulpi_stp
);
  logic run_b, wake_b;
  assign run_b  = vp_rd_data[POS_RUN];
  assign wake_b = vp_rd_data[POS_WAKE];

  assert_stp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_stp && !wake_b) |=> !ulpi_stp);

  assert_cmd_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VP_CMD) |-> (ulpi_data_oe &&
      ulpi_data_o[BYTE_W-1 -: 2] == (vp_rd_data[POS_DIR] ? OPC_WRITE : OPC_READ)));

  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_b && !ulpi_stp && state_q != VP_RCAPT) |=> run_b);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VP_CMD && ulpi_dir) |=> !ulpi_data_oe);

  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_b && ulpi_dir) |=> (wake_b && ulpi_stp));

  assert_fields_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_b || wake_b) |=> ($stable(vp_rd_data[7:0]) && $stable(vp_rd_data[26:16]) &&
                           $stable(vp_rd_data[POS_DIR])));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_b && wake_b));
endmodule

bind ulpi_viewport ulpi_viewport_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_q      (state_q),
  .vp_rd_data   (vp_rd_data),
  .ulpi_dir     (ulpi_dir),
  .ulpi_data_o  (ulpi_data_o),
  .ulpi_data_oe (ulpi_data_oe),
  .ulpi_stp     (ulpi_stp)
);

// File: tb/ulpi_viewport_tb.sv
module ulpi_viewport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vp_wr_en = 1'b0;
  logic [31:0] vp_wr_data = '0;
  logic [31:0] vp_rd_data;
  logic        phy_sync = 1'b0;
  logic        ulpi_dir = 1'b0;
  logic        ulpi_nxt = 1'b0;
  logic [7:0]  ulpi_data_i = '0;
  logic [7:0]  ulpi_data_o;
  logic        ulpi_data_oe;
  logic        ulpi_stp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ulpi_viewport u_dut (
    .clk(clk), .rst_n(rst_n), .vp_wr_en(vp_wr_en), .vp_wr_data(vp_wr_data),
    .vp_rd_data(vp_rd_data), .phy_sync(phy_sync), .ulpi_dir(ulpi_dir),
    .ulpi_nxt(ulpi_nxt), .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
    .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
  );

  // behavioural reference: phase names are strings of the bus activity
  string       ph = "idle";
  logic [7:0]  m_wd = 0, m_rd = 0, m_ad = 0;
  logic [2:0]  m_pt = 0;
  logic        m_wr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = "idle"; m_wd = 0; m_rd = 0; m_ad = 0; m_pt = 0; m_wr = 0;
    end else if (ph == "idle") begin
      if (vp_wr_en) begin
        m_wd = vp_wr_data[7:0]; m_ad = vp_wr_data[23:16];
        m_pt = vp_wr_data[26:24]; m_wr = vp_wr_data[29];
        if (vp_wr_data[30]) ph = "cmd";
        else if (vp_wr_data[31]) ph = "wake";
      end
    end else if (ph == "cmd") begin
      if (ulpi_dir) ph = "held";
      else if (ulpi_nxt) ph = m_wr ? "wbyte" : "turn";
    end else if (ph == "held") begin
      if (!ulpi_dir) ph = "cmd";
    end else if (ph == "wbyte") begin
      if (ulpi_nxt) ph = "stop";
    end else if (ph == "stop") begin
      ph = "idle";
    end else if (ph == "turn") begin
      if (ulpi_dir) ph = "grab";
    end else if (ph == "grab") begin
      m_rd = ulpi_data_i; ph = "idle";
    end else if (ph == "wake") begin
      if (!ulpi_dir) ph = "idle";
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0]  e_do;
      logic        e_oe, e_stp, e_run, e_wk;
      logic [31:0] e_rd;
      e_oe  = (ph == "cmd") || (ph == "wbyte") || (ph == "stop");
      e_stp = (ph == "stop") || (ph == "wake");
      e_wk  = (ph == "wake");
      e_run = !(ph == "idle") && !e_wk;
      e_do  = (ph == "cmd") ? {(m_wr ? 2'b10 : 2'b11), m_ad[5:0]} :
              (ph == "wbyte") ? m_wd : 8'h00;
      e_rd  = {e_wk, e_run, m_wr, 1'b0, phy_sync, m_pt, m_ad, m_rd, m_wd};
      chk(ulpi_data_o == e_do, "R3 R4 R6 bus byte", {24'h0, ulpi_data_o}, {24'h0, e_do});
      chk(ulpi_data_oe == e_oe, "R3 R4 R6 drive enable", {31'h0, ulpi_data_oe}, {31'h0, e_oe});
      chk(ulpi_stp == e_stp, "R3 R7 stop", {31'h0, ulpi_stp}, {31'h0, e_stp});
      chk(vp_rd_data == e_rd, "R1 R5 R8 R10 viewport word", vp_rd_data, e_rd);
    end
  end

  task automatic drive(input logic d, input logic n, input logic [7:0] di);
    ulpi_dir = d; ulpi_nxt = n; ulpi_data_i = di;
    @(posedge clk); #1;
  endtask

  task automatic cpu(input logic [31:0] w, input logic d, input logic n);
    vp_wr_en = 1'b1; vp_wr_data = w;
    drive(d, n, 8'h00);
    vp_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input bit wk, input bit rn, input bit wr,
      input logic [2:0] pt, input logic [7:0] ad, input logic [7:0] wd);
    return {wk, rn, wr, 1'b0, 1'b0, pt, ad, 8'h00, wd};
  endfunction

  initial begin
    for (int i = 0; i < 200000 && !done; i++) begin
      @(posedge clk); cycles++;
    end
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(vp_rd_data == 32'h0 && !ulpi_data_oe && !ulpi_stp && ulpi_data_o == 8'h00,
        "R11 reset state", vp_rd_data, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    drive(0, 0, 0);

    // R2: field load without starting
    cpu(word(0, 0, 1, 3'd5, 8'h2C, 8'h3D), 0, 0);
    @(negedge clk);
    chk(vp_rd_data == 32'h252C003D && !ulpi_data_oe, "R2 R1 idle field load",
        vp_rd_data, 32'h252C003D);
    @(posedge clk); #1;

    // R10: sync follows input
    phy_sync = 1'b1; #1;
    chk(vp_rd_data[27] == 1'b1, "R10 sync bit", {31'h0, vp_rd_data[27]}, 32'h1);
    drive(0, 0, 0);

    // R3: register write with stalled nxt, plus ignored strobe (R8)
    cpu(word(0, 1, 1, 3'd0, 8'h16, 8'hA5), 0, 0);
    cpu(word(0, 0, 0, 3'd7, 8'h01, 8'h11), 0, 0);
    @(negedge clk);
    chk(vp_rd_data[7:0] == 8'hA5 && vp_rd_data[30], "R8 busy strobe ignored",
        vp_rd_data, {vp_rd_data[31:8], 8'hA5});
    chk(ulpi_data_o == 8'h96, "R3 write command", {24'h0, ulpi_data_o}, 32'h96);
    @(posedge clk); #1;
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    @(negedge clk);
    chk(ulpi_stp == 1'b1, "R3 stop pulse", {31'h0, ulpi_stp}, 32'h1);
    @(posedge clk); #1;
    drive(0, 0, 0);
    @(negedge clk);
    chk(!vp_rd_data[30] && !ulpi_stp, "R5 run self-clears", vp_rd_data, {1'b0, 1'b0, vp_rd_data[29:0]});
    @(posedge clk); #1;

    // R4: register read
    cpu(word(0, 1, 0, 3'd3, 8'h0A, 8'h00), 0, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(1, 0, 8'hEE);
    drive(1, 0, 8'h5C);
    @(negedge clk);
    chk(vp_rd_data[15:8] == 8'h5C && !vp_rd_data[30], "R4 read capture",
        {24'h0, vp_rd_data[15:8]}, 32'h5C);
    chk(vp_rd_data[26:24] == 3'd3, "R1 port field", {29'h0, vp_rd_data[26:24]}, 32'h3);
    @(posedge clk); #1;
    drive(0, 0, 0);

    // R6: dir takes the bus mid-command; R5 clear attempt ignored
    cpu(word(0, 1, 1, 3'd0, 8'h3F, 8'h81), 0, 0);
    drive(1, 0, 8'h00);
    @(negedge clk);
    chk(!ulpi_data_oe, "R6 bus released", {31'h0, ulpi_data_oe}, 32'h0);
    @(posedge clk); #1;
    vp_wr_en = 1'b1; vp_wr_data = 32'h0;
    drive(1, 0, 8'h00);
    vp_wr_en = 1'b0;
    @(negedge clk);
    chk(vp_rd_data[30] == 1'b1, "R5 clear attempt ignored", vp_rd_data, vp_rd_data | 32'h4000_0000);
    @(posedge clk); #1;
    drive(0, 0, 0);
    @(negedge clk);
    chk(ulpi_data_oe && ulpi_data_o == 8'hBF, "R6 command retried",
        {24'h0, ulpi_data_o}, 32'hBF);
    @(posedge clk); #1;
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);

    // R7: wakeup
    drive(1, 0, 0);
    cpu(word(1, 0, 0, 3'd0, 8'h00, 8'h00), 1, 0);
    drive(1, 0, 0);
    drive(1, 0, 0);
    @(negedge clk);
    chk(vp_rd_data[31] && ulpi_stp, "R7 wakeup held", vp_rd_data, vp_rd_data | 32'h8000_0000);
    @(posedge clk); #1;
    drive(0, 0, 0);
    @(negedge clk);
    chk(!vp_rd_data[31] && !ulpi_stp, "R7 wakeup done", vp_rd_data, vp_rd_data & 32'h7FFF_FFFF);
    @(posedge clk); #1;

    // R9: both start bits
    cpu(word(1, 1, 1, 3'd0, 8'h04, 8'h77), 0, 0);
    @(negedge clk);
    chk(vp_rd_data[31:30] == 2'b01, "R9 run wins", {30'h0, vp_rd_data[31:30]}, 32'h1);
    @(posedge clk); #1;
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);
    drive(0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule